// File: doc/BRIEF.md
# Transmit Descriptor Engine

This block drives the transmit side of a descriptor-based Ethernet MAC. Software fills a ring of descriptors, each made of two 32-bit words: a status/control word followed by a pointer to the packet buffer. While transmission is enabled, the engine polls the descriptor at its current ring index. When that descriptor is marked ready, the engine settles the frame's limits and whether a CRC is wanted. It then pulls the packet from system memory one word at a time into a local byte buffer and streams it out one byte per cycle.

After the frame, the engine writes back a cleaned status word with the ready flag dropped. It pulses a success or error source line, optionally raises the interrupt, and steps to the next descriptor. Frames shorter than the minimum are padded with zero bytes. Frames over the allowed maximum, or too large for the buffer, are rejected without sending any bytes.

Status word layout, as used by the engine and by software:

| Bits | Field |
|------|-------|
| 31:16 | length |
| 15 | ready |
| 14 | interrupt request (kept) |
| 13 | wrap |
| 12 | pad |
| 11 | CRC |
| 10 | last |
| 9 | no-carrier |
| 8 | underrun |
| 7:4 | retry count |
| 3 | retransmit |
| 2 | reserved (kept) |
| 1 | defer |
| 0 | collision |

Top module: `txbd_engine`

## Requirements
- R1: The engine leaves its idle state only while `tx_en` is high. A ready descriptor causes no memory read, no byte and no write-back while `tx_en` stays low.
- R2: While waiting on a descriptor whose ready bit (15) is clear, the engine keeps polling the same index as long as `tx_en` is high, and makes no write. Once `tx_en` drops, it returns to idle and ignores a descriptor that becomes ready afterwards.
- R3: The length is taken from bits 31:16 of the status word, and the buffer pointer from the word at index+1. The flag bits sit at the positions given in the layout table above.
- R4: Packet words are read at pointer plus a byte offset that starts at 0 and grows by 4 per accepted read, until the offset reaches the length. A request is held with a stable address until `mem_ack`.
- R5: Each fetched word is emitted most significant byte first, one byte per `tx_valid` cycle. `tx_last` marks only the final byte.
- R6: When the pad flag (bit 12) or `pad_mode` is set, the frame minimum is `min_len`; otherwise it is the length. When the minimum exceeds the length, zero bytes are added until the minimum is reached. `frame_min` shows the minimum.
- R7: The frame maximum is the length when `huge_mode` is set, and `max_len` otherwise; `frame_max` shows it. A frame whose length exceeds the maximum, or exceeds the buffer of BUF_WORDS*4 bytes, sends no bytes and completes with an error.
- R8: `frame_crc` is high when `crc_mode` is set, or when the descriptor has both its CRC flag (bit 11) and its last flag (bit 10) set.
- R9: On completion the status word is written back to the same index with ready (15), no-carrier (9), underrun (8), retry (7:4), retransmit (3), defer (1) and collision (0) cleared. All other bits are kept.
- R10: In the write-back cycle, exactly one of `src_ok` (frame sent) or `src_err` (frame rejected) pulses.
- R11: `irq` pulses in the write-back cycle whenever `mask_ok` or `mask_err` is set, whatever the outcome.
- R12: After each frame the index grows by 2. It returns to 0 when the wrap flag (bit 13) was set, or when the index was DESC_WORDS-2.
- R13: After reset the index is 0 and `tx_valid`, `mem_req`, `desc_we`, `src_ok`, `src_err` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tx_en | input | 1 | transmit enable mode bit |
| pad_mode | input | 1 | global pad-to-minimum mode |
| crc_mode | input | 1 | global CRC append mode |
| huge_mode | input | 1 | lift the maximum-length limit |
| min_len | input | 16 | minimum frame length field |
| max_len | input | 16 | maximum frame length field |
| mask_ok | input | 1 | interrupt mask for sent frames |
| mask_err | input | 1 | interrupt mask for rejected frames |
| desc_addr | output | IDX_W (4) | current descriptor word index, read and write |
| desc_stat | input | 32 | descriptor word at `desc_addr` |
| desc_ptr | input | 32 | descriptor word at `desc_addr`+1 |
| desc_we | output | 1 | status write-back strobe |
| desc_wdata | output | 32 | status word written back |
| mem_req | output | 1 | memory word read request |
| mem_addr | output | 32 | memory byte address |
| mem_ack | input | 1 | read accepted, data valid |
| mem_rdata | input | 32 | memory read data |
| tx_valid | output | 1 | byte valid |
| tx_data | output | 8 | transmit byte |
| tx_last | output | 1 | final byte of frame |
| frame_min | output | 16 | resolved frame minimum |
| frame_max | output | 16 | resolved frame maximum |
| frame_crc | output | 1 | CRC wanted for this frame |
| src_ok | output | 1 | frame-sent source pulse |
| src_err | output | 1 | frame-error source pulse |
| irq | output | 1 | interrupt pulse |

## Verification
Some properties are checked on every cycle:
- a stalled memory request holds its address until acknowledged;
- bytes never overlap a memory request or a write-back;
- a rejected frame is never preceded by a byte;
- exactly one source fires per write-back;
- the ring index stays even and in range;
- the waiting state falls back to idle when enable drops.

Some behaviours only the bench's frame scenarios can show:
- the byte values and their order;
- the zero padding length;
- the resolution of minimum, maximum and CRC from mixed flags and modes;
- the exact bits cleared in the write-back;
- wrap by flag versus wrap by limit;
- the gating of the interrupt by the masks.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_FETCH = 2'd2,
      ST_SEND  = 2'd3
   } txbd_state_e;

   // status word layout
   localparam int LEN_HI   = 31;
   localparam int LEN_LO   = 16;
   localparam int BIT_RDY  = 15;
   localparam int BIT_IRQ  = 14;
   localparam int BIT_WRAP = 13;
   localparam int BIT_PAD  = 12;
   localparam int BIT_CRC  = 11;
   localparam int BIT_LAST = 10;

   // ready, no-carrier, underrun, retry[7:4], retransmit, defer, collision
   localparam logic [31:0] WB_CLEAR = 32'h0000_83FB;

endpackage

// File: rtl/txbd_cfg.sv
// Per-frame limit and CRC resolution from descriptor flags and mode bits.
module txbd_cfg
   import txbd_pkg::*;
#(
   parameter int BUF_BYTES = 64
)(
   input  logic [31:0] stat,
   input  logic        pad_mode,
   input  logic        crc_mode,
   input  logic        huge_mode,
   input  logic [15:0] min_len,
   input  logic [15:0] max_len,
   output logic [15:0] f_min,
   output logic [15:0] f_max,
   output logic [15:0] f_total,
   output logic        f_crc,
   output logic        f_bad
);
   logic [15:0] len;

   always_comb begin
      len     = stat[LEN_HI:LEN_LO];
      f_min   = (stat[BIT_PAD] | pad_mode) ? min_len : len;
      f_max   = huge_mode ? len : max_len;
      f_crc   = crc_mode | (stat[BIT_CRC] & stat[BIT_LAST]);
      f_bad   = (len > f_max) || (32'(len) > BUF_BYTES);
      f_total = (f_min > len) ? f_min : len;
   end

endmodule

// File: rtl/txbd_buf.sv
// Word-written, byte-read packet buffer with a selectable lane order.
module txbd_buf #(
   parameter int WORDS     = 16,
   parameter bit MSB_FIRST = 1'b1,
   localparam int BAW      = $clog2(WORDS * 4)
)(
   input  logic           clk,
   input  logic           we,
   input  logic [BAW-3:0] waddr,
   input  logic [31:0]    wdata,
   input  logic [BAW-1:0] ridx,
   output logic [7:0]     rbyte
);
   logic [31:0] mem [WORDS];
   logic [31:0] word;
   logic [1:0]  lane;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign word = mem[ridx[BAW-1:2]];

   generate
      if (MSB_FIRST) begin : g_msb
         assign lane = ~ridx[1:0];
      end else begin : g_lsb
         assign lane = ridx[1:0];
      end
   endgenerate

   assign rbyte = word[8*lane +: 8];

endmodule

// File: rtl/txbd_ring.sv
// Descriptor ring index: steps by one word pair, wraps on flag or limit.
module txbd_ring #(
   parameter int DESC_WORDS = 16,
   localparam int IDX_W     = $clog2(DESC_WORDS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wrap,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(DESC_WORDS - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (step)
         idx <= (wrap || idx >= LAST_PAIR) ? '0 : idx + IDX_W'(2);
   end

   assert_idx_even_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !idx[0] && (32'(idx) < DESC_WORDS));

endmodule

// File: rtl/txbd_engine.sv
module txbd_engine
   import txbd_pkg::*;
#(
   parameter int DESC_WORDS = 16,
   parameter int BUF_WORDS  = 16,
   localparam int IDX_W     = $clog2(DESC_WORDS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             pad_mode,
   input  logic             crc_mode,
   input  logic             huge_mode,
   input  logic [15:0]      min_len,
   input  logic [15:0]      max_len,
   input  logic             mask_ok,
   input  logic             mask_err,
   output logic [IDX_W-1:0] desc_addr,
   input  logic [31:0]      desc_stat,
   input  logic [31:0]      desc_ptr,
   output logic             desc_we,
   output logic [31:0]      desc_wdata,
   output logic             mem_req,
   output logic [31:0]      mem_addr,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   output logic [15:0]      frame_min,
   output logic [15:0]      frame_max,
   output logic             frame_crc,
   output logic             src_ok,
   output logic             src_err,
   output logic             irq
);
   localparam int BUF_BYTES = BUF_WORDS * 4;
   localparam int BAW       = $clog2(BUF_BYTES);

   generate
      if (DESC_WORDS < 4 || (DESC_WORDS % 2) != 0) begin : g_chk_desc
         $error("DESC_WORDS must be even and at least 4");
      end
      if (BUF_WORDS < 1 || (1 << $clog2(BUF_WORDS)) != BUF_WORDS) begin : g_chk_buf
         $error("BUF_WORDS must be a power of two");
      end
   endgenerate

   txbd_state_e state_q;
   logic [31:0] stat_q, ptr_q;
   logic [15:0] len_q, total_q, cnt_q;
   logic [16:0] off_q;
   logic        bad_q;

   logic [15:0] c_min, c_max, c_total;
   logic        c_crc, c_bad;
   logic        fetch_go, sending, finish;
   logic [7:0]  buf_byte;

   txbd_cfg #(.BUF_BYTES(BUF_BYTES)) u_cfg (
      .stat(desc_stat), .pad_mode(pad_mode), .crc_mode(crc_mode),
      .huge_mode(huge_mode), .min_len(min_len), .max_len(max_len),
      .f_min(c_min), .f_max(c_max), .f_total(c_total),
      .f_crc(c_crc), .f_bad(c_bad)
   );

   txbd_buf #(.WORDS(BUF_WORDS), .MSB_FIRST(1'b1)) u_buf (
      .clk(clk), .we(fetch_go), .waddr(off_q[BAW-1:2]), .wdata(mem_rdata),
      .ridx(cnt_q[BAW-1:0]), .rbyte(buf_byte)
   );

   txbd_ring #(.DESC_WORDS(DESC_WORDS)) u_ring (
      .clk(clk), .rst_n(rst_n), .step(finish),
      .wrap(stat_q[BIT_WRAP]), .idx(desc_addr)
   );

   always_comb begin
      mem_req    = (state_q == ST_FETCH) && (off_q < {1'b0, len_q});
      mem_addr   = ptr_q + 32'(off_q);
      fetch_go   = mem_req && mem_ack;
      sending    = (state_q == ST_SEND) && (cnt_q < total_q);
      finish     = (state_q == ST_SEND) && !sending;
      tx_valid   = sending;
      tx_data    = (cnt_q < len_q) ? buf_byte : 8'h00;
      tx_last    = sending && (cnt_q == total_q - 16'd1);
      desc_we    = finish;
      desc_wdata = stat_q & ~WB_CLEAR;
      src_ok     = finish && !bad_q;
      src_err    = finish && bad_q;
      irq        = finish && (mask_ok || mask_err);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         stat_q    <= '0;
         ptr_q     <= '0;
         len_q     <= '0;
         total_q   <= '0;
         cnt_q     <= '0;
         off_q     <= '0;
         bad_q     <= 1'b0;
         frame_min <= '0;
         frame_max <= '0;
         frame_crc <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (tx_en) state_q <= ST_WAIT;
            ST_WAIT: begin
               if (desc_stat[BIT_RDY]) begin
                  stat_q    <= desc_stat;
                  ptr_q     <= desc_ptr;
                  len_q     <= desc_stat[LEN_HI:LEN_LO];
                  frame_min <= c_min;
                  frame_max <= c_max;
                  frame_crc <= c_crc;
                  bad_q     <= c_bad;
                  total_q   <= c_bad ? 16'd0 : c_total;
                  off_q     <= '0;
                  cnt_q     <= '0;
                  state_q   <= c_bad ? ST_SEND : ST_FETCH;
               end else if (!tx_en) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_FETCH: begin
               if (fetch_go)      off_q   <= off_q + 17'd4;
               else if (!mem_req) state_q <= ST_SEND;
            end
            ST_SEND: begin
               if (sending) cnt_q   <= cnt_q + 16'd1;
               else         state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (!mem_req && !desc_we));

   assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |=> !tx_valid);

   assert_bad_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      src_err |-> !$past(tx_valid));

   assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> $onehot({src_ok, src_err}));

   assert_drop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !tx_en && !desc_stat[BIT_RDY]) |=> (state_q == ST_IDLE));

endmodule

// File: tb/txbd_engine_tb.sv
module txbd_engine_tb;

   localparam int DW   = 16;
   localparam int MINL = 20;
   localparam int MAXL = 40;

   typedef struct packed {
      logic [15:0] len;
      logic        dpad, dcrc, dlast, dwrap, gpad, gcrc, huge;
      logic [15:0] exp_total;
      logic        exp_crc, exp_bad;
   } vec_t;

   // len, dpad, dcrc, dlast, dwrap, gpad, gcrc, huge, total, crc, bad
   localparam vec_t VECS [12] = '{
      '{16'd8,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd8,  1'b0,1'b0},
      '{16'd8,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd20, 1'b0,1'b0},
      '{16'd8,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 16'd20, 1'b0,1'b0},
      '{16'd25, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd25, 1'b0,1'b0},
      '{16'd12, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 16'd12, 1'b1,1'b0},
      '{16'd12, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd12, 1'b0,1'b0},
      '{16'd12, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 16'd12, 1'b1,1'b0},
      '{16'd50, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,  1'b0,1'b1},
      '{16'd50, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'd50, 1'b0,1'b0},
      '{16'd70, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'd0,  1'b0,1'b1},
      '{16'd7,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd7,  1'b0,1'b0},
      '{16'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,  1'b0,1'b0}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic tx_en, pad_mode, crc_mode, huge_mode, mask_ok, mask_err;
   logic [15:0] min_len, max_len;
   logic [3:0]  desc_addr;
   logic [31:0] desc_stat, desc_ptr, desc_wdata, mem_addr, mem_rdata;
   logic desc_we, mem_req, mem_ack, tx_valid, tx_last, frame_crc;
   logic src_ok, src_err, irq, phase;
   logic [7:0]  tx_data;
   logic [15:0] frame_min, frame_max;

   logic [31:0] dram [DW];

   int checks = 0, errors = 0, cyc = 0;
   int nbytes, last_pos, act, exp_idx;
   logic [7:0] got [128];
   logic done, wb_ok, wb_err, wb_irq;
   logic [31:0] wb_data;
   logic [3:0]  wb_addr;

   always #10 clk = ~clk;   // 50 MHz

   txbd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .pad_mode(pad_mode),
      .crc_mode(crc_mode), .huge_mode(huge_mode), .min_len(min_len),
      .max_len(max_len), .mask_ok(mask_ok), .mask_err(mask_err),
      .desc_addr(desc_addr), .desc_stat(desc_stat), .desc_ptr(desc_ptr),
      .desc_we(desc_we), .desc_wdata(desc_wdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .frame_min(frame_min), .frame_max(frame_max), .frame_crc(frame_crc),
      .src_ok(src_ok), .src_err(src_err), .irq(irq)
   );

   // descriptor RAM and memory models; memory acknowledges every other cycle
   assign desc_stat = dram[desc_addr];
   assign desc_ptr  = dram[desc_addr + 4'd1];
   assign mem_ack   = mem_req & phase;
   assign mem_rdata = {mem_addr[7:0], mem_addr[7:0] + 8'd1,
                       mem_addr[7:0] + 8'd2, mem_addr[7:0] + 8'd3};

   always @(posedge clk) begin
      if (!rst_n) phase <= 1'b0;
      else        phase <= ~phase;
      if (desc_we) dram[desc_addr] <= desc_wdata;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req || desc_we || tx_valid) act++;
         if (tx_valid) begin
            if (nbytes < 128) got[nbytes] = tx_data;
            if (tx_last) last_pos = nbytes;
            nbytes++;
         end
         if (desc_we) begin
            wb_data = desc_wdata; wb_addr = desc_addr;
            wb_ok = src_ok; wb_err = src_err; wb_irq = irq; done = 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string what, input logic ok,
                        input longint actual, input longint expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, actual, expected);
      end
   endtask

   task automatic run_vec(input int i);
      vec_t v;
      logic [31:0] st, ptr, exp_wb;
      int exp_min, exp_max, bad_at;
      v   = VECS[i];
      st  = {v.len, 1'b1, 1'b1, v.dwrap, v.dpad, v.dcrc, v.dlast, 10'h3FF};
      ptr = 32'h4000 + 32'(i) * 32'h110;
      dram[exp_idx] = st;
      dram[exp_idx + 1] = ptr;
      pad_mode = v.gpad; crc_mode = v.gcrc; huge_mode = v.huge;
      nbytes = 0; last_pos = -1; done = 1'b0;
      tx_en = 1'b1;
      for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
      tx_en = 1'b0;
      exp_min = (v.dpad | v.gpad) ? MINL : int'(v.len);
      exp_max = v.huge ? int'(v.len) : MAXL;
      exp_wb  = st & ~32'h0000_83FB;
      check($sformatf("R6/R7 vec%0d byte count", i), nbytes == int'(v.exp_total), nbytes, v.exp_total);
      bad_at = -1;
      for (int k = 0; k < nbytes && k < 128; k++) begin
         logic [7:0] e;
         e = (k < int'(v.len)) ? 8'(ptr[7:0] + 8'(k)) : 8'h00;
         if (got[k] !== e && bad_at < 0) bad_at = k;
      end
      check($sformatf("R5/R4 vec%0d byte data first bad index", i), bad_at < 0, bad_at, -1);
      check($sformatf("R5 vec%0d last position", i), last_pos == int'(v.exp_total) - 1,
            last_pos, int'(v.exp_total) - 1);
      check($sformatf("R10 vec%0d ok/err", i), {wb_ok, wb_err} == {~v.exp_bad, v.exp_bad},
            {wb_ok, wb_err}, {~v.exp_bad, v.exp_bad});
      check($sformatf("R9/R3 vec%0d write-back word", i), wb_data == exp_wb, wb_data, exp_wb);
      check($sformatf("R12 vec%0d index", i), int'(wb_addr) == exp_idx, wb_addr, exp_idx);
      check($sformatf("R8 vec%0d crc", i), frame_crc == v.exp_crc, frame_crc, v.exp_crc);
      check($sformatf("R6 vec%0d frame_min", i), int'(frame_min) == exp_min, frame_min, exp_min);
      check($sformatf("R7 vec%0d frame_max", i), int'(frame_max) == exp_max, frame_max, exp_max);
      check($sformatf("R11 vec%0d irq", i), wb_irq == (mask_ok | mask_err), wb_irq, mask_ok | mask_err);
      exp_idx = (v.dwrap || exp_idx >= DW - 2) ? 0 : exp_idx + 2;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < DW; k++) dram[k] = '0;
      rst_n = 1'b0; tx_en = 1'b0; pad_mode = 1'b0; crc_mode = 1'b0; huge_mode = 1'b0;
      min_len = 16'(MINL); max_len = 16'(MAXL); mask_ok = 1'b1; mask_err = 1'b0;
      nbytes = 0; last_pos = -1; act = 0; done = 1'b0; exp_idx = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      check("R13 reset outputs", {tx_valid, mem_req, desc_we, src_ok, src_err, irq} == 6'b0,
            {tx_valid, mem_req, desc_we, src_ok, src_err, irq}, 0);
      check("R13 reset index", desc_addr == 4'd0, desc_addr, 0);

      // R1: ready descriptor ignored while tx_en low
      dram[0] = {16'd8, 1'b1, 15'd0}; dram[1] = 32'h4000;
      act = 0;
      repeat (30) @(negedge clk);
      check("R1 no activity with tx_en low", act == 0, act, 0);

      // R2: poll a not-ready descriptor, then drop tx_en and stay idle
      dram[0] = '0;
      tx_en = 1'b1; act = 0;
      repeat (30) @(negedge clk);
      check("R2 polling makes no access", act == 0, act, 0);
      check("R2 polling keeps index", desc_addr == 4'd0, desc_addr, 0);
      tx_en = 1'b0;
      repeat (5) @(negedge clk);
      dram[0] = {16'd8, 1'b1, 15'd0};
      act = 0;
      repeat (30) @(negedge clk);
      check("R2 idle after enable drop", act == 0, act, 0);
      dram[0] = '0;

      // table of frames
      for (int i = 0; i < 12; i++) run_vec(i);

      // R11: interrupt gated by masks (R12 limit wrap follows at index 14)
      mask_ok = 1'b0; mask_err = 1'b0;
      run_vec(0);
      mask_ok = 1'b0; mask_err = 1'b1;
      run_vec(0);
      check("R12 wrap at limit", exp_idx == 2, exp_idx, 2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule